// File: doc/BRIEF.md
# Interrupt Request Collector

This block gathers the interrupt request lines of a chip's subsystems into one pending-status word and produces a single interrupt line for the host processor. Four lines come from GPIO bank summaries, and a parameterised group of further lines comes from other peripherals. Each cycle the block samples every line into a status register. It forms the host interrupt from the sampled word, a per-peripheral enable field and a master enable bit.

The host sees two 16-bit registers through a small synchronous port. Address 0 is the read-only status word: bits 0 to 3 hold GPIO banks A to D in that order, and peripherals fill consecutive bits from bit 4 upward. Address 1 is the control word. It holds one enable bit per peripheral at the same bit position that peripheral has in the status word, and the master enable in bit 15. A status word whose meaningful bits are all zero means nothing is pending. A request is cleared at its source, never here. The interrupt output is a flop, so a downstream edge detector sees a clean transition.

Top module: `irq_aggregator`

## Requirements
- R1: One clock edge after a GPIO bank line changes, status bits 3:0 show bank request lines A..D (bit 0 = A, bit 3 = D).
- R2: One clock edge after a peripheral line changes, peripheral line k shows at status bit 4+k; status bits 15:10 always read as zero.
- R3: After reset the status word, the control word and `irq_o` are all zero.
- R4: A write to address 1 stores only bits 9:4 (peripheral enables, 1 = enabled) and bit 15 (master enable); all other control bits read as zero. A write to address 0 changes nothing.
- R5: While master enable (control bit 15) is 0, `irq_o` is 0 from the following edge onward, whatever is pending.
- R6: With master enable set, any set GPIO bank status bit drives `irq_o` high one edge after the status bit appears. Bank bits have no enable of their own.
- R7: A pending peripheral whose enable bit is 0 shows in status but does not raise `irq_o`. Setting its enable raises `irq_o` on the edge after the write.
- R8: Status does not latch: when a request line drops, its status bit clears one edge later, and `irq_o` clears on the edge after that if nothing else is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_req_i | input | NB (4) | GPIO bank request lines, index 0 = bank A |
| periph_req_i | input | NP (6) | Other peripheral request lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 status, 1 control |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt to the host |

## Verification
A request line reaches the status word one edge after it changes, and `irq_o` follows one edge after that. A control write acts on `irq_o` at the first edge after the write edge. Each task drives its inputs on a falling edge, advances the exact number of rising edges that the result needs, and samples on the next falling edge. The same tasks also check the cycle before a result is due, so a design that is one cycle early or one cycle late fails.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NB    = 4,
  parameter int NP    = 6,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    bank_req_i,
  input  logic [NP-1:0]    periph_req_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  localparam int SRC_W  = NB + NP;
  localparam int GE_BIT = REG_W - 1;
  localparam logic [REG_W-1:0] EN_FIELD = ((REG_W'(1) << NP) - REG_W'(1)) << NB;
  localparam logic [REG_W-1:0] GE_FIELD = REG_W'(1) << GE_BIT;

  logic [SRC_W-1:0] status_q;
  logic [REG_W-1:0] ctrl_q;
  logic [SRC_W-1:0] live;

  assign live      = status_q & {ctrl_q[NB +: NP], {NB{1'b1}}};
  assign rd_data_o = addr_i ? ctrl_q : REG_W'(status_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ctrl_q   <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= {periph_req_i, bank_req_i};
      if (wr_en_i && addr_i) ctrl_q <= wr_data_i & (EN_FIELD | GE_FIELD);
      irq_o    <= ctrl_q[GE_BIT] && (|live);
    end
  end

  // R1
  bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_data_o[NB-1:0] == $past(bank_req_i) || addr_i);

  // R5
  ge_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[GE_BIT] |=> !irq_o);

  // R6
  bank_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[GE_BIT] && |status_q[NB-1:0]) |=> irq_o);

  // R4
  ro_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !addr_i) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  logic clk = 0, rst_n = 0;
  logic [3:0] bank = '0;
  logic [5:0] per = '0;
  logic wr = 0, addr = 0;
  logic [15:0] wdata = '0, rdata;
  logic irq;
  int tests = 0, fails = 0;

  irq_aggregator u0 (.clk(clk), .rst_n(rst_n), .bank_req_i(bank), .periph_req_i(per),
    .wr_en_i(wr), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq));

  always #10 clk = ~clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic a, output logic [15:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic wr_reg(logic a, logic [15:0] d);
    addr = a; wdata = d; wr = 1; tick(); wr = 0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(0, v); chk("R3 status", v, 16'h0);
    rd(1, v); chk("R3 ctrl", v, 16'h0);
    chk("R3 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_bank;
    logic [15:0] v;
    bank = 4'b1010; rd(0, v); chk("R1 before edge", v, 16'h0);
    tick(); rd(0, v); chk("R1 bank status", v, 16'h000A);
    tick(); chk("R5 irq gated", 16'(irq), 16'h0);
    bank = 4'b0000; tick();
  endtask

  task automatic t_periph;
    logic [15:0] v;
    per = 6'b100001; tick(); rd(0, v); chk("R2 periph status", v, 16'h0210);
    per = 6'b111111; bank = 4'hF; tick(); rd(0, v); chk("R2 upper zero", v, 16'h03FF);
    per = '0; bank = '0; tick();
  endtask

  task automatic t_ctrl;
    logic [15:0] v;
    wr_reg(1, 16'hFFFF); rd(1, v); chk("R4 ctrl stored", v, 16'h83F0);
    wr_reg(0, 16'h0000); rd(1, v); chk("R4 status write ignored", v, 16'h83F0);
    wr_reg(1, 16'h0000); rd(1, v); chk("R4 ctrl cleared", v, 16'h0000);
  endtask

  task automatic t_bank_irq;
    logic [15:0] v;
    wr_reg(1, 16'h8000);
    bank = 4'b0001; tick(); chk("R6 irq not early", 16'(irq), 16'h0);
    tick(); chk("R6 bank irq", 16'(irq), 16'h1);
    bank = 4'b0000; tick(); rd(0, v); chk("R8 status cleared", v, 16'h0);
    chk("R8 irq still high", 16'(irq), 16'h1);
    tick(); chk("R8 irq cleared", 16'(irq), 16'h0);
  endtask

  task automatic t_masked;
    logic [15:0] v;
    per = 6'b000100; tick(); rd(0, v); chk("R7 pending visible", v, 16'h0040);
    tick(); chk("R7 disabled no irq", 16'(irq), 16'h0);
    wr_reg(1, 16'h8040); chk("R7 not at write edge", 16'(irq), 16'h0);
    tick(); chk("R7 enabled irq", 16'(irq), 16'h1);
    wr_reg(1, 16'h0040); chk("R5 irq before gate acts", 16'(irq), 16'h1);
    tick(); chk("R5 master off", 16'(irq), 16'h0);
    per = '0; tick(2);
  endtask

  initial begin
    #100000;
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(2);
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_bank();
    t_periph();
    t_ctrl();
    t_bank_irq();
    t_masked();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule